// File: doc/BRIEF.md
# Panel Switch Sample-Compare Filter

This block cleans up two groups of mechanical contacts on a control panel: an eight-bit word of zone contacts and a three-position rotary selector. It does not filter each bit separately. Each group is captured as a whole word, and that snapshot is checked again once a fixed number of slow ticks has passed. The new reading is accepted only when the second look matches the snapshot. Whatever the result, the second look becomes the next snapshot and the tick count restarts. The accepted results stay on the outputs until the next acceptance, and each update is marked by a one-cycle valid pulse.

The accepted selector value is decoded into an operating mode. When the selector reads "run" but the debounced zone word shows the panel's disable contact closed (low), the mode is reported as disable. Every completed selector acceptance also emits a one-cycle pulse that a supervisor can use as a watchdog kick. The 50 ms tick is supplied from outside and is assumed to be a one-cycle pulse.

Top module: `panel_switch_filter`

## Requirements
- R1: During and after synchronous active-low reset, until the first acceptance, zone_o reads 0x00, mode_o reads the run code, and zone_valid_o, mode_valid_o and wd_pulse_o are low.
- R2: A group's word is taken as a snapshot, and on the SETTLE_TICKS-th (default 10) later clock with tick_i high it is compared with the live input. On a match the snapshot is published; a zone publication raises zone_valid_o in the following cycle.
- R3: A mismatch at the compare point publishes nothing. The live value taken at that point becomes the new snapshot, so a reading that differs at every compare point is never published.
- R4: The selector is decoded from its top three bits, written top bit first: 110 gives run (code 0), 101 gives disable (code 1), 011 gives test (code 2), and every other pattern gives invalid (code 3).
- R5: If the decoded selector is run while the published zone word bit 6 is 0, mode_o becomes the disable code (1) instead.
- R6: Each selector publication produces exactly one wd_pulse_o pulse and one mode_valid_o pulse, one cycle after the selector is accepted. mode_o changes in that same cycle.
- R7: Between updates zone_o and mode_o hold their values. Each valid pulse lasts exactly one cycle.
- R8: Clocks without tick_i do not advance the compare window, so with no ticks nothing is published whatever the inputs do. The tick count restarts from zero with every new snapshot.
- R9: Zone bit 7 is inverted on entry, before any snapshot, so a raw 0 on bit 7 is published as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse every 50 ms |
| zone_raw_i | input | 8 | Raw zone contact word |
| sel_raw_i | input | 3 | Raw rotary selector bits |
| zone_o | output | 8 | Published zone word |
| zone_valid_o | output | 1 | One-cycle pulse when zone_o is updated |
| mode_o | output | 2 | Published mode code |
| mode_valid_o | output | 1 | One-cycle pulse when mode_o is updated |
| wd_pulse_o | output | 1 | Watchdog strobe, one per completed selector read |

## Verification
The bench toggles the zone word exactly once per window, so that every compare point sees the opposite value. A design that accepted on a partial match, or that kept an old snapshot after a mismatch, would publish a value there. It holds the tick low for long stretches while the inputs move, which catches a window that counts clocks instead of ticks. It sets up the run selector with the disable contact both open and closed and steps through all selector patterns. A missing override or a swapped code would show up as a wrong mode. Random phases compare every output on every cycle against a bench model, which exposes an off-by-one window length, a missing bit-7 inversion or a mode taken from the wrong cycle's zone word.

// File: rtl/panel_sw_pkg.sv
// Shared types for the panel switch filter.
// Assumes: the selector occupies at least three bits.
package panel_sw_pkg;

    typedef enum logic [1:0] {
        MODE_RUN     = 2'd0,
        MODE_DISABLE = 2'd1,
        MODE_TEST    = 2'd2,
        MODE_INVALID = 2'd3
    } mode_e;

    localparam logic [2:0] SEL_PAT_RUN     = 3'b110;
    localparam logic [2:0] SEL_PAT_DISABLE = 3'b101;
    localparam logic [2:0] SEL_PAT_TEST    = 3'b011;

endpackage

// File: rtl/sample_compare_deb.sv
// Whole-word sample-compare debouncer.
// Takes a snapshot of din, counts SETTLE_TICKS tick pulses, then compares
// the live input with the snapshot. On a match the snapshot is published
// with a one-cycle valid pulse. In either case the live value becomes the
// next snapshot and the count restarts at zero.
// Assumes: tick is a one-cycle pulse and SETTLE_TICKS >= 2.
module sample_compare_deb #(
    parameter int W            = 8,
    parameter int SETTLE_TICKS = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dvalid
);

    localparam int          CW   = $clog2(SETTLE_TICKS);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    logic          armed_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  snap_q;
    logic [W-1:0]  dout_q;
    logic          dvalid_q;
    logic          window_end;

    // Final tick of the current window.
    assign window_end = armed_q && tick && (cnt_q == LAST);

    // Snapshot, tick count, compare and publish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            cnt_q    <= '0;
            snap_q   <= '0;
            dout_q   <= '0;
            dvalid_q <= 1'b0;
        end else begin
            dvalid_q <= 1'b0;
            if (!armed_q) begin
                armed_q <= 1'b1;
                snap_q  <= din;
                cnt_q   <= '0;
            end else if (window_end) begin
                if (din == snap_q) begin
                    dout_q   <= snap_q;
                    dvalid_q <= 1'b1;
                end
                snap_q <= din;
                cnt_q  <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign dout   = dout_q;
    assign dvalid = dvalid_q;

    // R8: the window counter never passes its last value
    a_r8_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R7: a valid pulse is a single cycle
    a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_q |=> !dvalid_q);

    // R7: the published word only moves with a valid pulse
    a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid_q |-> $stable(dout_q));

    // R8: a publication always follows a sampled tick
    a_r8_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        dvalid_q |-> $past(tick));

endmodule

// File: rtl/zone_conditioner.sv
// Input conditioning for the zone word: flips the bits in INV_MASK so that
// the contacts wired active-high read the same way as the others.
// Assumes: purely combinational, applied before any snapshot.
module zone_conditioner #(
    parameter int          W        = 8,
    parameter logic [W-1:0] INV_MASK = 8'h80
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] cond
);

    // Per-bit polarity correction.
    for (genvar b = 0; b < W; b++) begin : g_bit
        if (INV_MASK[b]) begin : g_inv
            assign cond[b] = ~raw[b];
        end else begin : g_pass
            assign cond[b] = raw[b];
        end
    end

endmodule

// File: rtl/selector_decoder.sv
// Maps the top three selector bits to a mode and applies the disable
// override when run is selected but the disable contact reads low.
// Assumes: SEL_W >= 3; disable contact is bit DIS_BIT of the zone word.
module selector_decoder
    import panel_sw_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter int ZONE_W  = 8,
    parameter int DIS_BIT = 6
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [ZONE_W-1:0] zone,
    output mode_e             mode
);

    logic [2:0] top3;
    assign top3 = sel[SEL_W-1 -: 3];

    // Pattern match with disable override on run.
    always_comb begin
        unique case (top3)
            SEL_PAT_RUN:     mode = zone[DIS_BIT] ? MODE_RUN : MODE_DISABLE;
            SEL_PAT_DISABLE: mode = MODE_DISABLE;
            SEL_PAT_TEST:    mode = MODE_TEST;
            default:         mode = MODE_INVALID;
        endcase
    end

endmodule

// File: rtl/panel_switch_filter.sv
// Panel switch filter top. Debounces the zone word (after polarity
// correction) and the selector, decodes the mode one cycle after each
// selector acceptance, and emits a watchdog pulse with each mode update.
// Assumes: tick_i is a one-cycle pulse from an external 50 ms timebase.
module panel_switch_filter
    import panel_sw_pkg::*;
#(
    parameter int ZONE_W       = 8,
    parameter int SEL_W        = 3,
    parameter int SETTLE_TICKS = 10,
    parameter int INV_BIT      = 7,
    parameter int DIS_BIT      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ZONE_W-1:0] zone_raw_i,
    input  logic [SEL_W-1:0]  sel_raw_i,
    output logic [ZONE_W-1:0] zone_o,
    output logic              zone_valid_o,
    output logic [1:0]        mode_o,
    output logic              mode_valid_o,
    output logic              wd_pulse_o
);

    localparam logic [ZONE_W-1:0] INV_MASK = ZONE_W'(1) << INV_BIT;

    logic [ZONE_W-1:0] zone_cond;
    logic [ZONE_W-1:0] zone_q;
    logic              zone_vld;
    logic [SEL_W-1:0]  sel_q;
    logic              sel_vld;
    mode_e             mode_next;
    mode_e             mode_q;
    logic              mode_vld_q;
    logic              wd_q;

    zone_conditioner #(
        .W        (ZONE_W),
        .INV_MASK (INV_MASK)
    ) u_cond (
        .raw  (zone_raw_i),
        .cond (zone_cond)
    );

    sample_compare_deb #(
        .W            (ZONE_W),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_zone_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .din    (zone_cond),
        .dout   (zone_q),
        .dvalid (zone_vld)
    );

    sample_compare_deb #(
        .W            (SEL_W),
        .SETTLE_TICKS (SETTLE_TICKS)
    ) u_sel_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_i),
        .din    (sel_raw_i),
        .dout   (sel_q),
        .dvalid (sel_vld)
    );

    selector_decoder #(
        .SEL_W   (SEL_W),
        .ZONE_W  (ZONE_W),
        .DIS_BIT (DIS_BIT)
    ) u_dec (
        .sel  (sel_q),
        .zone (zone_q),
        .mode (mode_next)
    );

    // Mode register and watchdog strobe, loaded on selector publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_RUN;
            mode_vld_q <= 1'b0;
            wd_q       <= 1'b0;
        end else begin
            mode_vld_q <= sel_vld;
            wd_q       <= sel_vld;
            if (sel_vld) begin
                mode_q <= mode_next;
            end
        end
    end

    assign zone_o       = zone_q;
    assign zone_valid_o = zone_vld;
    assign mode_o       = mode_q;
    assign mode_valid_o = mode_vld_q;
    assign wd_pulse_o   = wd_q;

    // R5: run is reported only if the disable contact was open
    a_r5_run_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid_o && mode_o == MODE_RUN) |-> $past(zone_o[DIS_BIT]));

    // R6: watchdog pulse follows a selector publication
    a_r6_wd_after_sel: assert property (@(posedge clk) disable iff (!rst_n)
        wd_pulse_o |-> $past(sel_vld));

    // R7: mode holds between updates
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid_o |-> $stable(mode_o));

endmodule

// File: tb/panel_switch_filter_tb_top.sv
module panel_switch_filter_tb_top;

    localparam int SETTLE = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] zone_raw = 8'h00;
    logic [2:0] sel_raw = 3'b000;
    logic [7:0] zone_o;
    logic       zone_valid_o;
    logic [1:0] mode_o;
    logic       mode_valid_o;
    logic       wd_pulse_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 1'b0;
    int zv_count = 0;
    int wd_count = 0;

    always #4 clk = ~clk;

    panel_switch_filter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .zone_raw_i   (zone_raw),
        .sel_raw_i    (sel_raw),
        .zone_o       (zone_o),
        .zone_valid_o (zone_valid_o),
        .mode_o       (mode_o),
        .mode_valid_o (mode_valid_o),
        .wd_pulse_o   (wd_pulse_o)
    );

    // Mode expected from R4 and R5.
    function automatic logic [1:0] exp_mode(input logic [2:0] s, input logic [7:0] z);
        if (s == 3'b110) return z[6] ? 2'd0 : 2'd1;
        if (s == 3'b101) return 2'd1;
        if (s == 3'b011) return 2'd2;
        return 2'd3;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference state built from the requirements.
    logic       m_arm;
    logic [3:0] m_cnt;
    logic [7:0] m_zs, m_zone;
    logic [2:0] m_ss, m_sel;
    logic       m_zv, m_sv, m_mv, m_wd;
    logic [1:0] m_mode;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_arm <= 0; m_cnt <= 0; m_zs <= 0; m_zone <= 0; m_ss <= 0; m_sel <= 0;
            m_zv <= 0; m_sv <= 0; m_mv <= 0; m_wd <= 0; m_mode <= 2'd0;
        end else begin
            m_mv <= m_sv;
            m_wd <= m_sv;
            if (m_sv) m_mode <= exp_mode(m_sel, m_zone);
            m_zv <= 0;
            m_sv <= 0;
            if (!m_arm) begin
                m_arm <= 1; m_zs <= zone_raw ^ 8'h80; m_ss <= sel_raw; m_cnt <= 0;
            end else if (tick) begin
                if (m_cnt == 4'(SETTLE - 1)) begin
                    if ((zone_raw ^ 8'h80) == m_zs) begin m_zone <= m_zs; m_zv <= 1; end
                    if (sel_raw == m_ss) begin m_sel <= m_ss; m_sv <= 1; end
                    m_zs <= zone_raw ^ 8'h80;
                    m_ss <= sel_raw;
                    m_cnt <= 0;
                end else begin
                    m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (zone_valid_o) zv_count++;
        if (wd_pulse_o) wd_count++;
        if (cmp_en) begin
            check(zone_o == m_zone, "R2 zone word", 32'(zone_o), 32'(m_zone));
            check(zone_valid_o == m_zv, "R7 zone valid", 32'(zone_valid_o), 32'(m_zv));
            check(mode_o == m_mode, "R4 mode", 32'(mode_o), 32'(m_mode));
            check(wd_pulse_o == m_wd && mode_valid_o == m_mv, "R6 strobes",
                  {30'd0, wd_pulse_o, mode_valid_o}, {30'd0, m_wd, m_mv});
        end
    end

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R1: reset state
        check(zone_o == 8'h00, "R1 zone reset", 32'(zone_o), 32'h0);
        check(mode_o == 2'd0, "R1 mode reset", 32'(mode_o), 32'h0);
        check({zone_valid_o, mode_valid_o, wd_pulse_o} == 3'b000, "R1 strobes reset",
              32'({zone_valid_o, mode_valid_o, wd_pulse_o}), 32'h0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R9 / R4: run selector, all contacts normal, raw bit 7 low.
        zone_raw = 8'h7F; sel_raw = 3'b110;
        ticks(25);
        check(zone_o == 8'hFF, "R9 bit 7 inverted", 32'(zone_o), 32'hFF);
        check(mode_o == 2'd0, "R4 run", 32'(mode_o), 32'h0);

        // R5: disable contact closed while run selected.
        zone_raw = 8'h3F;
        ticks(25);
        check(zone_o == 8'hBF, "R5 zone word", 32'(zone_o), 32'hBF);
        check(mode_o == 2'd1, "R5 run overridden", 32'(mode_o), 32'h1);

        // R4: remaining selector patterns.
        zone_raw = 8'h7F;
        sel_raw = 3'b101; ticks(25);
        check(mode_o == 2'd1, "R4 disable", 32'(mode_o), 32'h1);
        sel_raw = 3'b011; ticks(25);
        check(mode_o == 2'd2, "R4 test", 32'(mode_o), 32'h2);
        sel_raw = 3'b000; ticks(25);
        check(mode_o == 2'd3, "R4 invalid 000", 32'(mode_o), 32'h3);
        sel_raw = 3'b111; ticks(25);
        check(mode_o == 2'd3, "R4 invalid 111", 32'(mode_o), 32'h3);

        // R6: one watchdog pulse per window while selector is steady.
        wd_count = 0;
        ticks(30);
        check(wd_count == 3, "R6 watchdog count", 32'(wd_count), 32'd3);

        // R3: zone flips once per window, so every compare mismatches.
        ticks(3);
        zv_count = 0;
        for (int k = 0; k < 10; k++) begin
            zone_raw = (k % 2 == 0) ? 8'h55 : 8'hAA;
            ticks(SETTLE);
        end
        check(zv_count == 0, "R3 no publish on mismatch", 32'(zv_count), 32'd0);
        check(zone_o == 8'hFF, "R3 zone held", 32'(zone_o), 32'hFF);

        // R8: no ticks, inputs moving, nothing published.
        zv_count = 0; wd_count = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (k % 7 == 0) zone_raw = 8'($urandom);
            if (k % 11 == 0) sel_raw = 3'($urandom);
        end
        check(zv_count == 0 && wd_count == 0, "R8 no ticks no update",
              32'(zv_count + wd_count), 32'd0);

        // Tick on every clock with steady inputs.
        zone_raw = 8'h12; sel_raw = 3'b110;
        for (int k = 0; k < 60; k++) begin @(negedge clk); tick = 1'b1; end
        @(negedge clk); tick = 1'b0;
        check(zone_o == 8'h92, "R2 continuous ticks", 32'(zone_o), 32'h92);
        check(mode_o == 2'd1, "R5 bit 6 low on run", 32'(mode_o), 32'h1);

        // Random phase against the reference state.
        for (int k = 0; k < 6000; k++) begin
            @(negedge clk);
            tick = ($urandom % 3 == 0);
            if ($urandom % 40 == 0) zone_raw = 8'($urandom);
            if ($urandom % 60 == 0) begin
                case ($urandom % 4)
                    0: sel_raw = 3'b110;
                    1: sel_raw = 3'b101;
                    2: sel_raw = 3'b011;
                    default: sel_raw = 3'($urandom);
                endcase
            end
        end

        // R1: reset mid-run restores the initial state.
        @(negedge clk); cmp_en = 1'b0; rst_n = 1'b0; tick = 1'b0;
        @(negedge clk); @(negedge clk);
        check(zone_o == 8'h00 && mode_o == 2'd0, "R1 reset again",
              {22'd0, zone_o, mode_o}, 32'h0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog against a hung run.
    initial begin
        #1200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule